// File: doc/BRIEF.md
# Carry-Skip Block Adder

A 16-bit combinational adder. It takes two operands and a carry-in, and it returns the sum and a carry-out. The width is cut into four groups of four bits. Inside each group the carry ripples through full-adder cells.

A group-wide skip condition is true when every bit of the group propagates. When it is true, the carry entering the group is forwarded straight to the group's carry output. The carry then does not wait on the four-cell ripple. When it is false, a generate or kill inside the group fixes the outgoing carry. In that case the rippled value is used. The group sums always come from the rippled carries, so the result is the same on either path.

The four group carries are brought out on their own port, so a datapath or a checker can observe them. In the worst case the carry ripples through the lowest group, skips each middle group, and then ripples through the top group before the sum is formed.

Top module: `carry_skip_adder`

## Requirements
- R1: `{cout, sum}` equals the 17-bit value `a + b + cin` for every operand pair and carry-in.
- R2: `group_cout[k]` equals bit 4k+4 of the sum of the low 4k+4 bits of `a`, the low 4k+4 bits of `b`, and `cin`, for k = 0..3.
- R3: When all four bits of group k satisfy `a XOR b = 1`, `group_cout[k]` equals the carry entering that group. That carry is `cin` for k = 0 and `group_cout[k-1]` otherwise.
- R4: When at least one bit of group k has `a XOR b = 0`, `group_cout[k]` is the carry out of that group's own 4-bit addition, and it does not depend on the carry entering the group.
- R5: `cout` always equals `group_cout[3]`.
- R6: With operands whose every bit propagates (for example 0xAAAA and 0x5555), `cin = 0` gives `sum = 0xFFFF`, `cout = 0` and `group_cout = 0000`. `cin = 1` gives `sum = 0x0000`, `cout = 1` and `group_cout = 1111`.
- R7: The block has no clock or state. The outputs follow a change of the inputs within the same time step, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 16 | Sum bits |
| cout | output | 1 | Carry out of bit 15 |
| group_cout | output | 4 | Carry out of each 4-bit group, bit k for bits 4k..4k+3 |

## Verification
Operand pairs whose bits all propagate exercise the skip path of every group at once. With them, cin alone decides all four group carries, so a broken bypass mux or skip condition shows up directly. Operands that generate everywhere and operands that kill everywhere hold the skip off in all groups. These patterns separate the rippled carry from the forwarded one and show that the incoming carry is ignored. Mixed patterns put a skipping group above a generating or killing group. Random vectors with a fixed seed cover the remaining mixes of skip and ripple, and for each vector every group carry is compared against a partial-sum model.

// File: rtl/csk_pkg.sv
package csk_pkg;
  localparam int DATA_W  = 16;
  localparam int GRP_W   = 4;
  localparam int NUM_GRP = DATA_W / GRP_W;

  // strobes from the skip control to the datapath
  typedef struct packed {
    logic [NUM_GRP-1:0] skip;
  } skipCtl_t;
endpackage

// File: rtl/csk_skip_ctl.sv
module csk_skip_ctl
  import csk_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int GW = GRP_W,
  localparam int NG = DW / GW
) (
  input  logic [DW-1:0] propBits,
  input  logic [DW-1:0] genBits,
  output skipCtl_t      ctl
);
  for (genvar k = 0; k < NG; k++) begin : gSkip
    assign ctl.skip[k] = &propBits[k*GW +: GW];

    // R3: a skipping group cannot also contain a generating bit
    always_comb begin
      if (ctl.skip[k])
        a_r3_skip_no_gen: assert (genBits[k*GW +: GW] == '0)
          else $error("skip asserted in group with a generate");
    end
  end
endmodule

// File: rtl/csk_group.sv
module csk_group #(
  parameter int GW = csk_pkg::GRP_W
) (
  input  logic [GW-1:0] propBits,
  input  logic [GW-1:0] genBits,
  input  logic          carryIn,
  output logic [GW-1:0] sumBits,
  output logic          rippleOut
);
  logic [GW:0] chain;

  assign chain[0] = carryIn;
  for (genvar i = 0; i < GW; i++) begin : gCell
    assign chain[i+1]  = genBits[i] | (propBits[i] & chain[i]);
    assign sumBits[i]  = propBits[i] ^ chain[i];
  end
  assign rippleOut = chain[GW];

  always_comb begin
    // R3: a fully propagating group ripples its own carry-in through
    if (&propBits)
      a_r3_ripple_equals_in: assert (rippleOut == carryIn)
        else $error("ripple differs from carry-in in propagating group");
    // R4: with no propagating bit, the top cell alone decides the carry
    if (propBits == '0)
      a_r4_top_cell_decides: assert (rippleOut == genBits[GW-1])
        else $error("ripple not set by top generate/kill");
  end
endmodule

// File: rtl/carry_skip_adder.sv
module carry_skip_adder
  import csk_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int GW = GRP_W,
  localparam int NG = DW / GW
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  output logic [DW-1:0] sum,
  output logic          cout,
  output logic [NG-1:0] group_cout
);
  logic [DW-1:0] propBits;
  logic [DW-1:0] genBits;
  logic [NG-1:0] grpIn;
  logic [NG-1:0] rippleOut;
  skipCtl_t      ctl;

  // setup stage
  assign propBits = a ^ b;
  assign genBits  = a & b;

  csk_skip_ctl #(.DW(DW), .GW(GW)) uCtl (
    .propBits (propBits),
    .genBits  (genBits),
    .ctl      (ctl)
  );

  for (genvar k = 0; k < NG; k++) begin : gGrp
    if (k == 0) begin : gFirst
      assign grpIn[k] = cin;
    end else begin : gNext
      assign grpIn[k] = group_cout[k-1];
    end

    csk_group #(.GW(GW)) uGrp (
      .propBits  (propBits[k*GW +: GW]),
      .genBits   (genBits[k*GW +: GW]),
      .carryIn   (grpIn[k]),
      .sumBits   (sum[k*GW +: GW]),
      .rippleOut (rippleOut[k])
    );

    // skip mux
    assign group_cout[k] = ctl.skip[k] ? grpIn[k] : rippleOut[k];

    // R2: both mux inputs agree, so the skip never changes the value
    always_comb begin
      a_r2_mux_inputs_agree: assert (rippleOut[k] == group_cout[k])
        else $error("skip path and ripple path disagree");
    end
  end

  assign cout = group_cout[NG-1];

  // R1: full result matches a behavioural sum
  always_comb begin
    a_r1_sum_matches: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin}))
      else $error("sum mismatch");
  end
endmodule

// File: tb/carry_skip_adder_test.sv
module carry_skip_adder_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] a = '0;
  logic [15:0] b = '0;
  logic        cin = 1'b0;
  logic [15:0] sum;
  logic        cout;
  logic [3:0]  group_cout;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  carry_skip_adder uut (
    .a(a), .b(b), .cin(cin),
    .sum(sum), .cout(cout), .group_cout(group_cout)
  );

  function automatic logic [16:0] expFull(logic [15:0] x, logic [15:0] y, logic c);
    return {1'b0, x} + {1'b0, y} + {16'd0, c};
  endfunction

  // carry out of the low 4k+4 bits
  function automatic logic expGrp(logic [15:0] x, logic [15:0] y, logic c, int k);
    logic [16:0] mask;
    logic [16:0] part;
    mask = (17'd1 << (4*k+4)) - 17'd1;
    part = ({1'b0, x} & mask) + ({1'b0, y} & mask) + {16'd0, c};
    return part[4*k+4];
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic applyAndCheck(logic [15:0] va, logic [15:0] vb, logic vc);
    logic [16:0] full;
    logic        cIntoGrp;
    logic [3:0]  pk;
    logic [4:0]  l0;
    @(negedge clk);
    a = va; b = vb; cin = vc;
    #1;
    full = expFull(va, vb, vc);
    chk("R1 result", {15'd0, cout, sum}, {15'd0, full});
    chk("R5 cout vs group3", {31'd0, cout}, {31'd0, group_cout[3]});
    for (int k = 0; k < 4; k++) begin
      chk("R2 group carry", {31'd0, group_cout[k]}, {31'd0, expGrp(va, vb, vc, k)});
      cIntoGrp = (k == 0) ? vc : expGrp(va, vb, vc, k-1);
      pk = 4'((va ^ vb) >> (4*k));
      if (pk == 4'hF) begin
        chk("R3 skip forwards carry", {31'd0, group_cout[k]}, {31'd0, cIntoGrp});
      end else begin
        l0 = {1'b0, 4'(va >> (4*k))} + {1'b0, 4'(vb >> (4*k))};
        chk("R4 local carry", {31'd0, group_cout[k]}, {31'd0, l0[4]});
      end
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] seedVal;
    repeat (3) @(posedge clk);
    #1;
    // reset-state check: zero inputs give zero outputs (R1)
    chk("R1 reset state", {11'd0, group_cout, cout, sum}, 32'd0);
    rst = 1'b0;

    // R6 all-propagate corners
    applyAndCheck(16'hAAAA, 16'h5555, 1'b0);
    chk("R6 sum all-prop cin0", {16'd0, sum}, 32'h0000FFFF);
    chk("R6 groups all-prop cin0", {28'd0, group_cout}, 32'h0);
    applyAndCheck(16'hAAAA, 16'h5555, 1'b1);
    chk("R6 sum all-prop cin1", {15'd0, cout, sum}, 32'h00010000);
    chk("R6 groups all-prop cin1", {28'd0, group_cout}, 32'hF);
    applyAndCheck(16'hFFFF, 16'h0000, 1'b1);

    // all-generate and all-kill: the incoming carry must not matter (R4)
    applyAndCheck(16'hFFFF, 16'hFFFF, 1'b0);
    applyAndCheck(16'hFFFF, 16'hFFFF, 1'b1);
    applyAndCheck(16'h0000, 16'h0000, 1'b1);
    applyAndCheck(16'h0000, 16'h0000, 1'b0);

    // skipping groups above a generating / killing group
    applyAndCheck(16'h0FF1, 16'hF00F, 1'b0);
    applyAndCheck(16'hF0F0, 16'h0F08, 1'b1);
    applyAndCheck(16'h00FF, 16'hFF00, 1'b1);
    applyAndCheck(16'h7FFF, 16'h0001, 1'b0);

    // R7: outputs follow inputs with no clock edge in between
    @(posedge clk);
    #1;
    a = 16'h1234; b = 16'h4321; cin = 1'b1;
    #1;
    chk("R7 no clock needed", {15'd0, cout, sum}, {15'd0, expFull(16'h1234, 16'h4321, 1'b1)});

    seedVal = $urandom(32'd20240611);
    for (int n = 0; n < 2000; n++) begin
      logic [15:0] ra;
      logic [15:0] rb;
      ra = 16'($urandom);
      rb = 16'($urandom);
      // bias some vectors toward full propagation in random groups
      if (n % 3 == 0) rb = ~ra ^ (16'($urandom) & 16'h0F0F);
      applyAndCheck(ra, rb, 1'($urandom));
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule